// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the fixed sequence a 32-bit processor follows when it enters an exception. A request carries either a vector number from the requesting source or, for a source that cannot supply one, an interrupt level from which the block makes an autovector number. The block takes a copy of the status register before changing it. It pushes a stack frame, tagged with its format, onto the active supervisor stack through a 16-bit write port. It then reads the new program counter from a relocatable vector table through a 32-bit read port. Finally it issues four long-word instruction prefetch requests and pulses `resume`.

An interrupt that arrives while the master bit is set needs a second step. After the first frame is on the master stack, the block clears the master bit and pushes a short format-1 frame onto the interrupt stack. After reset the block writes no frame. It reads the initial interrupt stack pointer and program counter from table slots 0 and 1, with the table base taken as zero. The updated program counter, status register and both stack pointers are presented on output ports.

The controller moves through these states. ST_BOOT is held while reset is asserted and always moves to ST_RST_SP. ST_RST_SP moves to ST_RST_PC when its read is acknowledged, and ST_RST_PC moves to ST_PREF on its acknowledge. ST_IDLE moves to ST_FRAME when it accepts a request. ST_FRAME stays in place while it writes the words of a frame and starts a second frame itself when one is needed. It moves to ST_VEC after the last word of the last frame. ST_VEC moves to ST_PREF on its read acknowledge, ST_PREF moves to ST_RESUME after the fourth prefetch acknowledge, and ST_RESUME always returns to ST_IDLE.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset is released, the block reads address 0 and then address 4 whatever `vbr_in` holds. It writes nothing. It loads `isp_out` from the first read and `pc_out` from the second, and it sets `sr_out` to 16'h2700.
- R2: For a request with a supplied vector number V, the program counter is read from `vbr_in` + 4·V, and `pc_out` takes the value returned.
- R3: When `req_auto` is set, the vector number is 24 + `req_level`. The read address and the frame's offset field both use this number, and the request is treated as an interrupt.
- R4: A frame of N words starts at final SP = initial SP − 2N. Word i sits at final SP + 2i. Word 0 is the status register before entry, word 1 is PC[31:16], word 2 is PC[15:0], and word 3 holds the format code in bits 15:12 and 4·vector in bits 11:0. The master stack is used when the old status register bit 12 (master) is set, and the interrupt stack otherwise.
- R5: Format codes 2 and 3 add 2 extra words, format 7 adds 26, and every other code adds none. Extra word k is the `xs_word` value presented while `xs_idx` = k, and it is written at final SP + 8 + 2k.
- R6: An interrupt (vectored or autovectored) with old bit 12 set first pushes its frame on the master stack. It then pushes a 4-word format-1 frame at `isp_in` − 8 whose status word is the new status register. Bit 12 of `sr_out` is cleared, and both stack pointer outputs show the lowered values.
- R7: The new status register clears bits 15:14 (trace) and sets bit 13 (supervisor). For interrupts it writes `req_level` into bits 10:8. It keeps every other bit, including bit 12 unless R6 applies.
- R8: After the program counter is loaded, prefetch requests go to PC, PC+4, PC+8 and PC+12 in that order. `resume` then pulses high for exactly one cycle.
- R9: `busy` is high from the cycle after acceptance until the `resume` cycle. A request is accepted only in ST_IDLE, and a request held through a busy period is taken once the block returns to idle.
- R10: While a write, read or prefetch request waits for its acknowledge, its address and data do not change.
- R11: At most one of `wr_en`, `rd_req` and `pf_req` is high in any cycle, and none is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts the boot sequence |
| vbr_in | input | 32 | Vector table base, sampled on request acceptance |
| req_valid | input | 1 | Exception request, held until `busy` rises |
| req_vec | input | 8 | Supplied vector number |
| req_auto | input | 1 | Use the autovector number made from `req_level` |
| req_irq | input | 1 | Request is an interrupt |
| req_level | input | 3 | Interrupt level being serviced |
| req_fmt | input | 4 | Frame format code |
| req_pc | input | 32 | Program counter to save |
| req_sr | input | 16 | Status register before entry |
| msp_in | input | 32 | Master stack pointer |
| isp_in | input | 32 | Interrupt stack pointer |
| busy | output | 1 | Sequence in progress |
| resume | output | 1 | One-cycle pulse: execution may resume |
| wr_en | output | 1 | Frame word write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 16 | Write data |
| wr_rdy | input | 1 | Write accepted this cycle |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Read byte address |
| rd_data | input | 32 | Read data, valid with `rd_ack` |
| rd_ack | input | 1 | Read completes this cycle |
| pf_req | output | 1 | Long-word prefetch request |
| pf_addr | output | 32 | Prefetch address |
| pf_ack | input | 1 | Prefetch accepted this cycle |
| xs_idx | output | 5 | Index of the extra state word wanted |
| xs_word | input | 16 | Extra state word for `xs_idx` |
| pc_out | output | 32 | Loaded program counter |
| sr_out | output | 16 | Updated status register |
| isp_out | output | 32 | Updated interrupt stack pointer |
| msp_out | output | 32 | Updated master stack pointer |

## Verification
The assertions check the port discipline on every cycle. They check that address and data are held under a stalled handshake, that only one memory port is requested at a time, that the ports stay silent while idle, that `resume` lasts one cycle inside a busy period, and that the status register leaves trace off and supervisor on at `resume`. Only the directed scenarios can show the values themselves. These are the frame addresses and word contents for each format, the autovector arithmetic, the second frame on the interrupt stack, the reset reads from base zero, the order of the prefetch addresses, and the deferral of a request that is held while the block is busy.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 16;
    localparam int OFF_W      = 12;
    localparam int FMT_W      = 4;
    localparam int BASE_WORDS = 4;

    localparam int SR_T1  = 15;
    localparam int SR_T0  = 14;
    localparam int SR_S   = 13;
    localparam int SR_M   = 12;
    localparam int SR_IPL = 8;

    localparam logic [WORD_W-1:0] BOOT_SR   = 16'h2700;
    localparam logic [FMT_W-1:0]  FMT_SHORT = 4'h1;
    localparam int                AUTO_BASE = 24;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RST_SP,
        ST_RST_PC,
        ST_IDLE,
        ST_FRAME,
        ST_VEC,
        ST_PREF,
        ST_RESUME
    } seq_state_t;

    // number of processor-state words appended after the four base words
    function automatic int extra_words(input logic [FMT_W-1:0] fmt);
        case (fmt)
            4'h2, 4'h3: return 2;
            4'h7:       return 26;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_seq_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LVL_W = 3
) (
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              req_auto,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [VEC_W-1:0]  tbl_idx,
    output logic [VEC_W-1:0]  vec_num,
    output logic [ADDR_W-1:0] tbl_addr
);

    // autovector: fixed base plus the serviced level
    always_comb begin
        if (req_auto)
            vec_num = VEC_W'(AUTO_BASE) + VEC_W'(req_level);
        else
            vec_num = req_vec;
    end

    // each table entry is one long word
    assign tbl_addr = tbl_base + (ADDR_W'(tbl_idx) << 2);

endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word
    import exc_seq_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] sr_word,
    input  logic [ADDR_W-1:0] pc,
    input  logic [FMT_W-1:0]  fmt,
    input  logic [VEC_W-1:0]  vec,
    input  logic [WORD_W-1:0] xs_word,
    output logic [IDX_W-1:0]  xs_idx,
    output logic [WORD_W-1:0] word
);

    logic [OFF_W-1:0] offset;

    assign offset = OFF_W'({vec, 2'b00});
    assign xs_idx = (widx >= IDX_W'(BASE_WORDS)) ? widx - IDX_W'(BASE_WORDS) : '0;

    always_comb begin
        case (widx)
            IDX_W'(0): word = sr_word;
            IDX_W'(1): word = pc[31:16];
            IDX_W'(2): word = pc[15:0];
            IDX_W'(3): word = {fmt, offset};
            default:   word = xs_word;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int LVL_W      = 3,
    parameter int IDX_W      = 5,
    parameter int PREFETCHES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       vbr_in,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic              req_auto,
    input  logic              req_irq,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [3:0]        req_fmt,
    input  logic [31:0]       req_pc,
    input  logic [15:0]       req_sr,
    input  logic [31:0]       msp_in,
    input  logic [31:0]       isp_in,
    output logic              busy,
    output logic              resume,
    output logic              wr_en,
    output logic [31:0]       wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_rdy,
    output logic              rd_req,
    output logic [31:0]       rd_addr,
    input  logic [31:0]       rd_data,
    input  logic              rd_ack,
    output logic              pf_req,
    output logic [31:0]       pf_addr,
    input  logic              pf_ack,
    output logic [IDX_W-1:0]  xs_idx,
    input  logic [15:0]       xs_word,
    output logic [31:0]       pc_out,
    output logic [15:0]       sr_out,
    output logic [31:0]       isp_out,
    output logic [31:0]       msp_out
);

    localparam int PF_W = (PREFETCHES > 1) ? $clog2(PREFETCHES) : 1;

    seq_state_t state, nxt;

    logic [IDX_W-1:0]  widx, nwords;
    logic [ADDR_W-1:0] fsp;
    logic [FMT_W-1:0]  fmt_r;
    logic [WORD_W-1:0] frame_sr;
    logic              second_r, dual_r, use_msp_r;
    logic [VEC_W-1:0]  vec_r;
    logic [ADDR_W-1:0] pc_save_r, vbr_r;
    logic [WORD_W-1:0] sr_r;
    logic [ADDR_W-1:0] pc_r, isp_r, msp_r;
    logic [PF_W-1:0]   pf_cnt;

    // request decode
    logic              take, is_irq, dual_now, last_word, more_frame;
    logic [VEC_W-1:0]  vec_num;
    logic [IDX_W-1:0]  n_req;
    logic [ADDR_W-1:0] sp_sel;
    logic [WORD_W-1:0] new_sr;

    // table lookup
    logic [ADDR_W-1:0] tbl_base, tbl_addr;
    logic [VEC_W-1:0]  tbl_idx;
    logic [WORD_W-1:0] frame_word;

    assign take       = (state == ST_IDLE) && req_valid;
    assign is_irq     = req_irq | req_auto;
    assign dual_now   = is_irq & req_sr[SR_M];
    assign n_req      = IDX_W'(BASE_WORDS + extra_words(req_fmt));
    assign sp_sel     = req_sr[SR_M] ? msp_in : isp_in;
    assign last_word  = (widx == nwords - IDX_W'(1));
    assign more_frame = dual_r & ~second_r;

    always_comb begin
        new_sr        = req_sr;
        new_sr[SR_T1] = 1'b0;
        new_sr[SR_T0] = 1'b0;
        new_sr[SR_S]  = 1'b1;
        if (is_irq)
            new_sr[SR_IPL +: LVL_W] = req_level;
        if (dual_now)
            new_sr[SR_M] = 1'b0;
    end

    always_comb begin
        if (state == ST_RST_SP) begin
            tbl_base = '0;
            tbl_idx  = VEC_W'(0);
        end else if (state == ST_RST_PC) begin
            tbl_base = '0;
            tbl_idx  = VEC_W'(1);
        end else begin
            tbl_base = vbr_r;
            tbl_idx  = vec_r;
        end
    end

    exc_vec_addr #(
        .VEC_W (VEC_W),
        .LVL_W (LVL_W)
    ) u_vec (
        .req_vec   (req_vec),
        .req_level (req_level),
        .req_auto  (req_auto),
        .tbl_base  (tbl_base),
        .tbl_idx   (tbl_idx),
        .vec_num   (vec_num),
        .tbl_addr  (tbl_addr)
    );

    exc_frame_word #(
        .VEC_W (VEC_W),
        .IDX_W (IDX_W)
    ) u_word (
        .widx    (widx),
        .sr_word (frame_sr),
        .pc      (pc_save_r),
        .fmt     (fmt_r),
        .vec     (vec_r),
        .xs_word (xs_word),
        .xs_idx  (xs_idx),
        .word    (frame_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:   nxt = ST_RST_SP;
            ST_RST_SP: if (rd_ack) nxt = ST_RST_PC;
            ST_RST_PC: if (rd_ack) nxt = ST_PREF;
            ST_IDLE:   if (req_valid) nxt = ST_FRAME;
            ST_FRAME:  if (wr_rdy && last_word && !more_frame) nxt = ST_VEC;
            ST_VEC:    if (rd_ack) nxt = ST_PREF;
            ST_PREF:   if (pf_ack && pf_cnt == PF_W'(PREFETCHES - 1)) nxt = ST_RESUME;
            ST_RESUME: nxt = ST_IDLE;
            default:   nxt = ST_BOOT;
        endcase
    end

    // port strobes
    always_comb begin
        busy    = 1'b1;
        resume  = 1'b0;
        wr_en   = 1'b0;
        rd_req  = 1'b0;
        pf_req  = 1'b0;
        wr_addr = fsp + (ADDR_W'(widx) << 1);
        wr_data = frame_word;
        rd_addr = tbl_addr;
        pf_addr = pc_r + (ADDR_W'(pf_cnt) << 2);
        unique case (state)
            ST_BOOT:   ;
            ST_RST_SP: rd_req = 1'b1;
            ST_RST_PC: rd_req = 1'b1;
            ST_IDLE:   busy   = 1'b0;
            ST_FRAME:  wr_en  = 1'b1;
            ST_VEC:    rd_req = 1'b1;
            ST_PREF:   pf_req = 1'b1;
            ST_RESUME: resume = 1'b1;
            default:   ;
        endcase
    end

    // sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx      <= '0;
            nwords    <= '0;
            fsp       <= '0;
            fmt_r     <= '0;
            frame_sr  <= '0;
            second_r  <= 1'b0;
            dual_r    <= 1'b0;
            use_msp_r <= 1'b0;
            vec_r     <= '0;
            pc_save_r <= '0;
            vbr_r     <= '0;
            sr_r      <= BOOT_SR;
            pc_r      <= '0;
            isp_r     <= '0;
            msp_r     <= '0;
            pf_cnt    <= '0;
        end else begin
            if (take) begin
                vec_r     <= vec_num;
                pc_save_r <= req_pc;
                vbr_r     <= vbr_in;
                fmt_r     <= req_fmt;
                frame_sr  <= req_sr;
                sr_r      <= new_sr;
                nwords    <= n_req;
                widx      <= '0;
                fsp       <= sp_sel - (ADDR_W'(n_req) << 1);
                second_r  <= 1'b0;
                dual_r    <= dual_now;
                use_msp_r <= req_sr[SR_M];
                msp_r     <= msp_in;
                isp_r     <= isp_in;
            end
            if (state == ST_FRAME && wr_rdy) begin
                if (last_word) begin
                    if (use_msp_r && !second_r) msp_r <= fsp;
                    else                        isp_r <= fsp;
                    if (more_frame) begin
                        second_r <= 1'b1;
                        fsp      <= isp_r - ADDR_W'(2 * BASE_WORDS);
                        nwords   <= IDX_W'(BASE_WORDS);
                        fmt_r    <= FMT_SHORT;
                        frame_sr <= sr_r;
                        widx     <= '0;
                    end
                end else begin
                    widx <= widx + IDX_W'(1);
                end
            end
            if (state == ST_RST_SP && rd_ack)
                isp_r <= rd_data;
            if ((state == ST_RST_PC || state == ST_VEC) && rd_ack) begin
                pc_r   <= rd_data;
                pf_cnt <= '0;
            end
            if (state == ST_PREF && pf_ack)
                pf_cnt <= pf_cnt + PF_W'(1);
        end
    end

    assign pc_out  = pc_r;
    assign sr_out  = sr_r;
    assign isp_out = isp_r;
    assign msp_out = msp_r;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        resume,
    input logic        wr_en,
    input logic        wr_rdy,
    input logic [31:0] wr_addr,
    input logic [15:0] wr_data,
    input logic        rd_req,
    input logic        rd_ack,
    input logic [31:0] rd_addr,
    input logic        pf_req,
    input logic        pf_ack,
    input logic [31:0] pf_addr,
    input logic [15:0] sr_out
);

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_rdy) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_pf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req && !pf_ack) |=> (pf_req && $stable(pf_addr)));

    assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_req, pf_req}));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(wr_en || rd_req || pf_req));

    assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    assert_resume_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> busy);

    assert_sr_super_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (sr_out[13] && sr_out[15:14] == 2'b00));

endmodule

bind exc_entry_seq exc_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .resume  (resume),
    .wr_en   (wr_en),
    .wr_rdy  (wr_rdy),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .rd_addr (rd_addr),
    .pf_req  (pf_req),
    .pf_ack  (pf_ack),
    .pf_addr (pf_addr),
    .sr_out  (sr_out)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/100ps
module sim_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vbr_in = '0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        req_auto = 1'b0;
    logic        req_irq = 1'b0;
    logic [2:0]  req_level = '0;
    logic [3:0]  req_fmt = '0;
    logic [31:0] req_pc = '0;
    logic [15:0] req_sr = '0;
    logic [31:0] msp_in = '0;
    logic [31:0] isp_in = '0;
    logic        busy, resume, wr_en, rd_req, pf_req;
    logic [31:0] wr_addr, rd_addr, pf_addr, rd_data;
    logic [15:0] wr_data, xs_word;
    logic        wr_rdy, rd_ack, pf_ack;
    logic [4:0]  xs_idx;
    logic [31:0] pc_out, isp_out, msp_out;
    logic [15:0] sr_out;

    logic        stall_en = 1'b0;
    logic        tgl = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) tgl <= ~tgl;

    function automatic logic [31:0] rom(input logic [31:0] a);
        return 32'h0010_0000 + (a << 4);
    endfunction

    function automatic logic [15:0] xs_of(input int k);
        return 16'hC000 + 16'(k * 7);
    endfunction

    assign wr_rdy  = !stall_en || tgl;
    assign rd_ack  = rd_req && (!stall_en || tgl);
    assign pf_ack  = pf_req && (!stall_en || !tgl);
    assign rd_data = rom(rd_addr);
    assign xs_word = xs_of(int'(xs_idx));

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .vbr_in(vbr_in), .req_valid(req_valid),
        .req_vec(req_vec), .req_auto(req_auto), .req_irq(req_irq),
        .req_level(req_level), .req_fmt(req_fmt), .req_pc(req_pc),
        .req_sr(req_sr), .msp_in(msp_in), .isp_in(isp_in), .busy(busy),
        .resume(resume), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_rdy(wr_rdy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_ack(rd_ack), .pf_req(pf_req), .pf_addr(pf_addr), .pf_ack(pf_ack),
        .xs_idx(xs_idx), .xs_word(xs_word), .pc_out(pc_out), .sr_out(sr_out),
        .isp_out(isp_out), .msp_out(msp_out)
    );

    // handshake logs
    logic [31:0] wl_a [256];
    logic [15:0] wl_d [256];
    logic [31:0] rl_a [64];
    logic [31:0] pl_a [64];
    int wn = 0, rn = 0, pn = 0, clash = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_en && wr_rdy && wn < 256) begin wl_a[wn] = wr_addr; wl_d[wn] = wr_data; wn++; end
            if (rd_req && rd_ack && rn < 64) begin rl_a[rn] = rd_addr; rn++; end
            if (pf_req && pf_ack && pn < 64) begin pl_a[pn] = pf_addr; pn++; end
            if (int'(wr_en) + int'(rd_req) + int'(pf_req) > 1) clash++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_busy();
        int n = 0;
        while (!busy && n < 2000) begin @(negedge clk); n++; end
        if (!busy) chk(1'b0, "R9 watchdog waiting for busy", 32'(busy), 32'd1);
    endtask

    task automatic wait_resume();
        int n = 0;
        while (!resume && n < 4000) begin @(negedge clk); n++; end
        if (!resume) chk(1'b0, "R8 watchdog waiting for resume", 32'(resume), 32'd1);
    endtask

    task automatic check_prefetch(input int p0, input logic [31:0] pc, input string tag);
        chk(pn - p0 == 4, {tag, " R8 prefetch count"}, 32'(pn - p0), 32'd4);
        for (int k = 0; k < 4; k++)
            if (p0 + k < pn)
                chk(pl_a[p0 + k] == pc + 32'(4 * k), {tag, " R8 prefetch address"}, pl_a[p0 + k], pc + 32'(4 * k));
    endtask

    // boot sequence after reset release (R1)
    task automatic t_boot();
        int w0, r0, p0;
        vbr_in = 32'h0000_3000;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1 && !rd_req && !wr_en && !pf_req && !resume, "R1 reset state quiet",
            {27'd0, busy, rd_req, wr_en, pf_req, resume}, 32'h10);
        w0 = wn; r0 = rn; p0 = pn;
        rst_n = 1'b1;
        wait_resume();
        chk(rn - r0 == 2, "R1 boot read count", 32'(rn - r0), 32'd2);
        chk(rl_a[r0] == 32'd0, "R1 first boot read at 0", rl_a[r0], 32'd0);
        chk(rl_a[r0 + 1] == 32'd4, "R1 second boot read at 4", rl_a[r0 + 1], 32'd4);
        chk(wn == w0, "R1 no frame written", 32'(wn - w0), 32'd0);
        chk(isp_out == rom(32'd0), "R1 isp loaded", isp_out, rom(32'd0));
        chk(pc_out == rom(32'd4), "R1 pc loaded", pc_out, rom(32'd4));
        chk(sr_out == 16'h2700, "R1 boot status", 32'(sr_out), 32'h2700);
        check_prefetch(p0, rom(32'd4), "boot");
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after boot", 32'(busy), 32'd0);
    endtask

    // one exception entry, expected values worked out from the requirements
    task automatic run_exc(input string tag, input logic [7:0] vec, input bit auto, input bit irq,
                           input logic [2:0] lvl, input logic [3:0] fmt, input logic [31:0] pc,
                           input logic [15:0] sr, input logic [31:0] msp, input logic [31:0] isp,
                           input logic [31:0] vbr, input bit stall);
        logic [31:0] ea [64];
        logic [15:0] ed [64];
        int en = 0;
        int w0, r0, p0, x, n;
        bit intr, dual, usem;
        logic [7:0]  v;
        logic [11:0] off;
        logic [31:0] sp, f1, f2, vaddr, emsp, eisp;
        logic [15:0] nsr;
        intr = irq | auto;
        v    = auto ? 8'(24 + int'(lvl)) : vec;
        off  = 12'({v, 2'b00});
        x    = (fmt == 4'h2 || fmt == 4'h3) ? 2 : (fmt == 4'h7) ? 26 : 0;
        n    = 4 + x;
        usem = sr[12];
        dual = intr && usem;
        sp   = usem ? msp : isp;
        f1   = sp - 32'(2 * n);
        f2   = isp - 32'd8;
        nsr  = (sr & 16'h3FFF) | 16'h2000;
        if (intr) nsr[10:8] = lvl;
        if (dual) nsr[12] = 1'b0;
        for (int i = 0; i < n; i++) begin
            ea[en] = f1 + 32'(2 * i);
            case (i)
                0: ed[en] = sr;
                1: ed[en] = pc[31:16];
                2: ed[en] = pc[15:0];
                3: ed[en] = {fmt, off};
                default: ed[en] = xs_of(i - 4);
            endcase
            en++;
        end
        if (dual) begin
            ea[en] = f2;       ed[en] = nsr;        en++;
            ea[en] = f2 + 2;   ed[en] = pc[31:16];  en++;
            ea[en] = f2 + 4;   ed[en] = pc[15:0];   en++;
            ea[en] = f2 + 6;   ed[en] = {4'h1, off}; en++;
        end
        emsp  = usem ? f1 : msp;
        eisp  = dual ? f2 : (usem ? isp : f1);
        vaddr = vbr + (32'(v) << 2);

        stall_en = stall;
        req_vec = vec; req_auto = auto; req_irq = irq; req_level = lvl; req_fmt = fmt;
        req_pc = pc; req_sr = sr; msp_in = msp; isp_in = isp; vbr_in = vbr;
        w0 = wn; r0 = rn; p0 = pn;
        req_valid = 1'b1;
        @(negedge clk);
        wait_busy();
        req_valid = 1'b0;
        msp_in = 32'hDEAD_0000; isp_in = 32'hBEEF_0000; vbr_in = 32'hFFFF_0000;
        wait_resume();
        chk(wn - w0 == en, {tag, " R4 R5 R6 frame word count"}, 32'(wn - w0), 32'(en));
        for (int i = 0; i < en; i++)
            if (w0 + i < wn) begin
                chk(wl_a[w0 + i] == ea[i], {tag, " R4 R6 frame word address"}, wl_a[w0 + i], ea[i]);
                chk(wl_d[w0 + i] == ed[i], {tag, " R4 R5 R10 frame word data"}, 32'(wl_d[w0 + i]), 32'(ed[i]));
            end
        chk(rn - r0 == 1, {tag, " R2 one vector read"}, 32'(rn - r0), 32'd1);
        chk(rl_a[r0] == vaddr, {tag, " R2 R3 vector address"}, rl_a[r0], vaddr);
        chk(pc_out == rom(vaddr), {tag, " R2 pc loaded"}, pc_out, rom(vaddr));
        chk(sr_out == nsr, {tag, " R7 new status"}, 32'(sr_out), 32'(nsr));
        chk(msp_out == emsp, {tag, " R4 R6 master stack"}, msp_out, emsp);
        chk(isp_out == eisp, {tag, " R4 R6 interrupt stack"}, isp_out, eisp);
        check_prefetch(p0, rom(vaddr), tag);
        @(negedge clk);
        chk(!resume && !busy, {tag, " R8 R9 single resume then idle"}, {30'd0, resume, busy}, 32'd0);
        stall_en = 1'b0;
    endtask

    // request held across a busy period (R9)
    task automatic t_held();
        int r0;
        stall_en = 1'b0;
        vbr_in = 32'h0004_0000; msp_in = 32'h0000_A000; isp_in = 32'h0000_B000;
        req_auto = 1'b0; req_irq = 1'b0; req_level = 3'd0; req_fmt = 4'h0;
        req_pc = 32'h0000_1230; req_sr = 16'h2000; req_vec = 8'd64;
        r0 = rn;
        req_valid = 1'b1;
        @(negedge clk);
        wait_busy();
        req_vec = 8'd65;
        wait_resume();
        chk(rn - r0 == 1 && rl_a[r0] == 32'h0004_0100, "R9 first request served first",
            rl_a[r0], 32'h0004_0100);
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle before taking held request", 32'(busy), 32'd0);
        @(negedge clk);
        chk(busy == 1'b1, "R9 held request taken from idle", 32'(busy), 32'd1);
        req_valid = 1'b0;
        wait_resume();
        chk(rn - r0 == 2 && rl_a[r0 + 1] == 32'h0004_0104, "R9 held request vector address",
            rl_a[r0 + 1], 32'h0004_0104);
        @(negedge clk);
    endtask

    initial begin
        t_boot();
        run_exc("plain_fmt2", 8'd5, 1'b0, 1'b0, 3'd0, 4'h2, 32'h0000_4444, 16'hC013,
                32'h0000_9000, 32'h0000_7000, 32'h0000_2000, 1'b1);
        run_exc("autovec_l5", 8'd0, 1'b1, 1'b0, 3'd5, 4'h0, 32'h1234_5678, 16'h0200,
                32'h0000_9000, 32'h0000_7000, 32'h0000_8000, 1'b0);
        run_exc("irq_dual", 8'd70, 1'b0, 1'b1, 3'd3, 4'h0, 32'hCAFE_0010, 16'h3000,
                32'h0000_9100, 32'h0000_7100, 32'h0001_0000, 1'b0);
        run_exc("long_fmt7", 8'd2, 1'b0, 1'b0, 3'd0, 4'h7, 32'h0040_0002, 16'hB400,
                32'h0000_9800, 32'h0000_7800, 32'h0000_0400, 1'b1);
        run_exc("auto_l7_dual", 8'd0, 1'b1, 1'b0, 3'd7, 4'h3, 32'h0000_ABC0, 16'h7100,
                32'h0000_6000, 32'h0000_5000, 32'h0000_C000, 1'b1);
        t_held();
        chk(clash == 0, "R11 one port request per cycle", 32'(clash), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL global watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule